// File: doc/BRIEF.md
# Two-Level Page Entry Permission Checker

This block makes the access decision for one address translation. It takes the directory-level entry, the page-level entry, the linear address, the access kind and the current privilege level. It decides whether the access may proceed. If it may not, it returns a fault with a reason code. If it may, it forms the physical address and passes out the page's cache-control attributes.

It also returns both entry words with their status flags updated, so that the surrounding page walker can write them back. A separate write-back strobe for each level is raised only when that word actually changed.

The decision logic is combinational. Its result sits behind a single registered output stage with a valid/ready handshake. A request is accepted on a clock edge where both `in_valid` and `in_ready` are high. Its result is presented from the following cycle and stays stable until the consumer takes it.

Top module: `pgperm_check`

## Requirements
- R1: If bit 0 (present) of either entry is clear, the result carries fault code 1, `out_ok` is low, both returned words equal the inputs, and both strobes are low. All other bits of an absent entry have no effect.
- R2: When the privilege level is 3 and bit 2 (user) is not set in both entries, the fault code is 2. At levels 0, 1 and 2, bit 2 never causes a fault.
- R3: A write (`in_wr` = 1) when bit 1 (writable) is not set in both entries gives fault code 3, at any privilege level.
- R4: When several causes apply, code 1 wins over code 2, and code 2 wins over code 3. Code 0 with `out_ok` high means the access is allowed.
- R5: On an allowed read or write, bit 5 (accessed) is set in both returned words.
- R6: Bit 6 (dirty) is set in the returned page-level word only on an allowed write. Bit 6 of the directory word and all other bits of both words come back unchanged.
- R7: On an allowed access, `out_phys` is page-entry bits 31:12 joined with linear address bits 11:0. On a fault it is zero.
- R8: On an allowed access, `out_nocache` equals page-entry bit 4 and `out_wthru` equals page-entry bit 3. Both are zero on a fault.
- R9: A write-back strobe is high only when the returned word for that level differs from its input word.
- R10: `in_ready` is high whenever the output register is empty or is being drained. An accepted request shows its result in the next cycle. The result is held stable while `out_valid` is high and `out_ready` is low.
- R11: During and immediately after reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_dir | input | 32 | Directory-level entry |
| in_pg | input | 32 | Page-level entry |
| in_wr | input | 1 | 1 = write access, 0 = read access |
| in_cpl | input | 2 | Current privilege level |
| in_lin | input | 32 | Linear address |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_ok | output | 1 | Access allowed |
| out_fault | output | 2 | 0 none, 1 not present, 2 privilege, 3 write |
| out_phys | output | 32 | Physical address |
| out_nocache | output | 1 | Page must not be cached |
| out_wthru | output | 1 | Write hits must also update memory |
| out_dir | output | 32 | Updated directory entry |
| out_pg | output | 32 | Updated page entry |
| out_dir_wb | output | 1 | Directory word needs writing back |
| out_pg_wb | output | 1 | Page word needs writing back |

## Verification
The bound checker tests several properties on every cycle:
- An accepted request with an absent entry yields code 1.
- A level-3 request without user permission at both levels yields code 2.
- A supervisor request never yields code 2.
- The directory's dirty bit is never changed.
- Allowed results always carry both accessed bits.
- Faulting results never raise a strobe.
- A stalled result does not move.

Other behaviour can only be shown by the bench's scenarios, which compare against a separately written model. This covers:
- the exact physical address;
- the attribute pass-through;
- whether each strobe is set or clear, according to which flags were already set;
- the priority order when several fault causes overlap.

// File: rtl/pgperm_pkg.sv
package pgperm_pkg;
   // Entry flag positions; a walker and this block must agree on them.
   localparam int unsigned FB_PRESENT = 0;
   localparam int unsigned FB_WRITE   = 1;
   localparam int unsigned FB_USER    = 2;
   localparam int unsigned FB_WTHRU   = 3;
   localparam int unsigned FB_NOCACHE = 4;
   localparam int unsigned FB_ACCESS  = 5;
   localparam int unsigned FB_DIRTY   = 6;
   localparam int unsigned FB_TOP     = 8;

   typedef enum logic [1:0] {
      FLT_NONE   = 2'd0,
      FLT_ABSENT = 2'd1,
      FLT_PRIV   = 2'd2,
      FLT_WRITE  = 2'd3
   } fault_e;
endpackage

// File: rtl/pgperm_decode.sv
module pgperm_decode
   import pgperm_pkg::*;
#(
   parameter int unsigned ENTRY_W  = 32,
   parameter int unsigned LEVELS   = 2,
   parameter int unsigned CPL_W    = 2,
   parameter int unsigned USER_CPL = 3
) (
   input  logic [LEVELS-1:0][ENTRY_W-1:0] ent,
   input  logic                           wr,
   input  logic [CPL_W-1:0]               cpl,
   output fault_e                         fault,
   output logic                           ok
);
   logic [LEVELS-1:0] pres;
   logic [LEVELS-1:0] usr;
   logic [LEVELS-1:0] wen;

   for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
      assign pres[g] = ent[g][FB_PRESENT];
      assign usr[g]  = ent[g][FB_USER];
      assign wen[g]  = ent[g][FB_WRITE];
   end

   logic all_present;
   logic user_allowed;
   logic write_allowed;
   logic user_mode;

   assign all_present   = &pres;
   assign user_allowed  = &usr;
   assign write_allowed = &wen;
   assign user_mode     = (cpl >= CPL_W'(USER_CPL));

   always_comb begin
      if (!all_present)                   fault = FLT_ABSENT;
      else if (user_mode && !user_allowed) fault = FLT_PRIV;
      else if (wr && !write_allowed)      fault = FLT_WRITE;
      else                                fault = FLT_NONE;
   end

   assign ok = (fault == FLT_NONE);

   logic unused_ent_bits;
   assign unused_ent_bits = ^ent;
endmodule

// File: rtl/pgperm_update.sv
module pgperm_update
   import pgperm_pkg::*;
#(
   parameter int unsigned ENTRY_W = 32,
   parameter int unsigned LEVELS  = 2
) (
   input  logic [LEVELS-1:0][ENTRY_W-1:0] ent,
   input  logic                           ok,
   input  logic                           wr,
   output logic [LEVELS-1:0][ENTRY_W-1:0] nxt,
   output logic [LEVELS-1:0]              wb
);
   for (genvar g = 0; g < LEVELS; g++) begin : g_lvl
      logic [ENTRY_W-1:0] set_mask;
      if (g == LEVELS - 1) begin : g_leaf
         always_comb begin
            set_mask = '0;
            set_mask[FB_ACCESS] = ok;
            set_mask[FB_DIRTY]  = ok & wr;
         end
      end else begin : g_inner
         always_comb begin
            set_mask = '0;
            set_mask[FB_ACCESS] = ok;
         end
      end
      assign nxt[g] = ent[g] | set_mask;
      assign wb[g]  = |(set_mask & ~ent[g]);
   end
endmodule

// File: rtl/pgperm_xlate.sv
module pgperm_xlate
   import pgperm_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned PAGE_SHIFT = 12
) (
   input  logic [ADDR_W-1:0]     leaf,
   input  logic [PAGE_SHIFT-1:0] offset,
   input  logic                  ok,
   output logic [ADDR_W-1:0]     phys,
   output logic                  nocache,
   output logic                  wthru
);
   assign phys    = ok ? {leaf[ADDR_W-1:PAGE_SHIFT], offset} : '0;
   assign nocache = ok & leaf[FB_NOCACHE];
   assign wthru   = ok & leaf[FB_WTHRU];

   logic unused_leaf_low;
   assign unused_leaf_low = ^leaf[PAGE_SHIFT-1:0];
endmodule

// File: rtl/pgperm_outstage.sv
module pgperm_outstage #(
   parameter int unsigned DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   output logic          in_ready,
   input  logic [DW-1:0] in_data,
   output logic          out_valid,
   input  logic          out_ready,
   output logic [DW-1:0] out_data
);
   logic          vld_q;
   logic [DW-1:0] dat_q;

   assign in_ready  = !vld_q || out_ready;
   assign out_valid = vld_q;
   assign out_data  = dat_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q <= 1'b0;
         dat_q <= '0;
      end else begin
         if (in_ready) vld_q <= in_valid;
         if (in_valid && in_ready) dat_q <= in_data;
      end
   end
endmodule

// File: rtl/pgperm_check.sv
module pgperm_check
   import pgperm_pkg::*;
#(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned PAGE_SHIFT = 12,
   parameter int unsigned CPL_W      = 2,
   parameter int unsigned USER_CPL   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [ADDR_W-1:0] in_dir,
   input  logic [ADDR_W-1:0] in_pg,
   input  logic              in_wr,
   input  logic [CPL_W-1:0]  in_cpl,
   input  logic [ADDR_W-1:0] in_lin,
   output logic              out_valid,
   input  logic              out_ready,
   output logic              out_ok,
   output logic [1:0]        out_fault,
   output logic [ADDR_W-1:0] out_phys,
   output logic              out_nocache,
   output logic              out_wthru,
   output logic [ADDR_W-1:0] out_dir,
   output logic [ADDR_W-1:0] out_pg,
   output logic              out_dir_wb,
   output logic              out_pg_wb
);
   localparam int unsigned ENTRY_W = ADDR_W;
   localparam int unsigned LEVELS  = 2;
   localparam int unsigned LEAF    = LEVELS - 1;
   localparam int unsigned DW      = 2 + 1 + ADDR_W + 2 + LEVELS * ENTRY_W + LEVELS;

   if (PAGE_SHIFT <= FB_TOP) begin : g_bad_shift
      $error("PAGE_SHIFT must leave room for the flag bits");
   end
   if (ADDR_W <= PAGE_SHIFT) begin : g_bad_addr
      $error("ADDR_W must exceed PAGE_SHIFT");
   end
   if (USER_CPL >= (1 << CPL_W)) begin : g_bad_cpl
      $error("USER_CPL does not fit in CPL_W bits");
   end

   logic [LEVELS-1:0][ENTRY_W-1:0] ent;
   logic [LEVELS-1:0][ENTRY_W-1:0] nxt;
   logic [LEVELS-1:0]              wb;
   fault_e                         fault;
   logic                           ok;
   logic [ADDR_W-1:0]              phys;
   logic                           nocache;
   logic                           wthru;

   assign ent[0]    = in_dir;
   assign ent[LEAF] = in_pg;

   pgperm_decode #(
      .ENTRY_W(ENTRY_W), .LEVELS(LEVELS), .CPL_W(CPL_W), .USER_CPL(USER_CPL)
   ) u_decode (
      .ent(ent), .wr(in_wr), .cpl(in_cpl), .fault(fault), .ok(ok)
   );

   pgperm_update #(
      .ENTRY_W(ENTRY_W), .LEVELS(LEVELS)
   ) u_update (
      .ent(ent), .ok(ok), .wr(in_wr), .nxt(nxt), .wb(wb)
   );

   pgperm_xlate #(
      .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)
   ) u_xlate (
      .leaf(in_pg), .offset(in_lin[PAGE_SHIFT-1:0]), .ok(ok),
      .phys(phys), .nocache(nocache), .wthru(wthru)
   );

   logic [DW-1:0] stage_in;
   logic [DW-1:0] stage_out;

   assign stage_in = {fault, ok, phys, nocache, wthru, nxt[0], nxt[LEAF], wb[0], wb[LEAF]};

   pgperm_outstage #(
      .DW(DW)
   ) u_stage (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(stage_in),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(stage_out)
   );

   assign {out_fault, out_ok, out_phys, out_nocache, out_wthru,
           out_dir, out_pg, out_dir_wb, out_pg_wb} = stage_out;

   logic unused_lin_high;
   assign unused_lin_high = ^in_lin[ADDR_W-1:PAGE_SHIFT];
endmodule

// File: rtl/pgperm_check_sva.sv
module pgperm_check_sva #(
   parameter int unsigned ADDR_W   = 32,
   parameter int unsigned CPL_W    = 2,
   parameter int unsigned USER_CPL = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_ready,
   input logic [ADDR_W-1:0] in_dir,
   input logic [ADDR_W-1:0] in_pg,
   input logic [CPL_W-1:0]  in_cpl,
   input logic              out_valid,
   input logic              out_ready,
   input logic              out_ok,
   input logic [1:0]        out_fault,
   input logic [ADDR_W-1:0] out_phys,
   input logic [ADDR_W-1:0] out_dir,
   input logic [ADDR_W-1:0] out_pg,
   input logic              out_dir_wb,
   input logic              out_pg_wb
);
   logic acc;
   assign acc = in_valid && in_ready;

   logic unused_sva;
   assign unused_sva = ^{in_dir, in_pg};

   p_absent_r1: assert property (@(posedge clk) disable iff (!rst_n)
      acc && (!in_dir[0] || !in_pg[0]) |=> out_valid && out_fault == 2'd1);

   p_priv_r2: assert property (@(posedge clk) disable iff (!rst_n)
      acc && in_dir[0] && in_pg[0] && in_cpl == CPL_W'(USER_CPL) && !(in_dir[2] && in_pg[2])
      |=> out_valid && out_fault == 2'd2);

   p_super_r2: assert property (@(posedge clk) disable iff (!rst_n)
      acc && in_cpl != CPL_W'(USER_CPL) |=> out_fault != 2'd2);

   p_okcode_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_ok == (out_fault == 2'd0)));

   p_accessed_r5: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ok |-> out_dir[5] && out_pg[5]);

   p_dirdirty_r6: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> out_dir[6] == $past(in_dir[6]));

   p_faultwb_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ok |-> !out_dir_wb && !out_pg_wb);

   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_fault) && $stable(out_phys)
                                  && $stable(out_dir) && $stable(out_pg));
endmodule

bind pgperm_check pgperm_check_sva #(
   .ADDR_W(ADDR_W), .CPL_W(CPL_W), .USER_CPL(USER_CPL)
) u_sva (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .in_dir(in_dir), .in_pg(in_pg), .in_cpl(in_cpl),
   .out_valid(out_valid), .out_ready(out_ready), .out_ok(out_ok),
   .out_fault(out_fault), .out_phys(out_phys), .out_dir(out_dir), .out_pg(out_pg),
   .out_dir_wb(out_dir_wb), .out_pg_wb(out_pg_wb)
);

// File: tb/pgperm_check_bench.sv
module pgperm_check_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_dir = '0;
   logic [31:0] in_pg = '0;
   logic        in_wr = 1'b0;
   logic [1:0]  in_cpl = '0;
   logic [31:0] in_lin = '0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic        out_ok;
   logic [1:0]  out_fault;
   logic [31:0] out_phys;
   logic        out_nocache;
   logic        out_wthru;
   logic [31:0] out_dir;
   logic [31:0] out_pg;
   logic        out_dir_wb;
   logic        out_pg_wb;

   int unsigned n_chk = 0;
   int unsigned n_bad = 0;
   bit          drain = 1'b0;
   bit          done = 1'b0;

   logic [102:0] exp_q[$];
   string        tag_q[$];

   always #10 clk = ~clk;

   pgperm_check u_pgperm_check (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_dir(in_dir), .in_pg(in_pg), .in_wr(in_wr), .in_cpl(in_cpl), .in_lin(in_lin),
      .out_valid(out_valid), .out_ready(out_ready), .out_ok(out_ok), .out_fault(out_fault),
      .out_phys(out_phys), .out_nocache(out_nocache), .out_wthru(out_wthru),
      .out_dir(out_dir), .out_pg(out_pg), .out_dir_wb(out_dir_wb), .out_pg_wb(out_pg_wb)
   );

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   // Model: {code, ok, phys, nocache, wthru, dir, pg, dir_wb, pg_wb}
   function automatic logic [102:0] model(input logic [31:0] d, input logic [31:0] p,
                                          input logic w, input logic [1:0] c, input logic [31:0] l);
      logic [1:0]  code;
      logic        allow;
      logic [31:0] ph, nd, np;
      logic        nc, wt, dwb, pwb;
      if (!d[0] || !p[0])                 code = 2'd1;
      else if (c == 2'd3 && !(d[2] && p[2])) code = 2'd2;
      else if (w && !(d[1] && p[1]))       code = 2'd3;
      else                                 code = 2'd0;
      allow = (code == 2'd0);
      ph = 32'h0; nc = 1'b0; wt = 1'b0; nd = d; np = p; dwb = 1'b0; pwb = 1'b0;
      if (allow) begin
         ph  = {p[31:12], l[11:0]};
         nc  = p[4];
         wt  = p[3];
         nd  = d | 32'h20;
         np  = p | 32'h20 | (w ? 32'h40 : 32'h0);
         dwb = !d[5];
         pwb = !p[5] || (w && !p[6]);
      end
      return {code, allow, ph, nc, wt, nd, np, dwb, pwb};
   endfunction

   task automatic send(input logic [31:0] d, input logic [31:0] p, input logic w,
                       input logic [1:0] c, input logic [31:0] l, input string tag);
      @(negedge clk);
      in_valid = 1'b1; in_dir = d; in_pg = p; in_wr = w; in_cpl = c; in_lin = l;
      #1;
      while (!in_ready) begin
         @(negedge clk);
         #1;
      end
      exp_q.push_back(model(d, p, w, c, l));
      tag_q.push_back(tag);
   endtask

   // Output side: random back-pressure, hold check, result compare.
   initial begin : monitor
      bit          hold_pend;
      logic [97:0] snap;
      hold_pend = 1'b0;
      snap = '0;
      while (!done) begin
         @(negedge clk);
         out_ready = drain ? 1'b1 : (($urandom % 4) != 0);
         #1;
         if (hold_pend)
            chk("R10", "held result", {30'h0, out_valid, out_fault, out_phys, out_pg[31:0]} ,
                {30'h0, 1'b1, snap[66:0]});
         hold_pend = out_valid && !out_ready;
         snap = {31'h0, out_fault, out_phys, out_pg};
         if (out_valid && out_ready) begin
            if (exp_q.size() == 0) begin
               chk("R10", "unexpected result", 64'd1, 64'd0);
            end else begin
               logic [102:0] e;
               string        t, ft;
               logic [1:0]   e_code;
               logic         e_ok, e_nc, e_wt, e_dwb, e_pwb;
               logic [31:0]  e_phys, e_dir, e_pg;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               {e_code, e_ok, e_phys, e_nc, e_wt, e_dir, e_pg, e_dwb, e_pwb} = e;
               ft = (t != "") ? t : (e_code == 2'd1) ? "R1" : (e_code == 2'd2) ? "R2" :
                    (e_code == 2'd3) ? "R3" : "R4";
               chk(ft, "fault code/ok", {61'h0, out_fault, out_ok}, {61'h0, e_code, e_ok});
               chk("R7", "phys", {32'h0, out_phys}, {32'h0, e_phys});
               chk("R8", "attrs", {62'h0, out_nocache, out_wthru}, {62'h0, e_nc, e_wt});
               chk(e_ok ? "R5" : "R1", "dir word", {32'h0, out_dir}, {32'h0, e_dir});
               chk("R6", "page word", {32'h0, out_pg}, {32'h0, e_pg});
               chk("R9", "strobes", {62'h0, out_dir_wb, out_pg_wb}, {62'h0, e_dwb, e_pwb});
            end
         end
      end
   end

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin : main
      int unsigned seed;
      seed = $urandom(32'h1a2b3c);
      repeat (3) @(negedge clk);
      #1;
      chk("R11", "out_valid in reset", {63'h0, out_valid}, 64'd0);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk("R11", "out_valid after reset", {63'h0, out_valid}, 64'd0);
      chk("R11", "in_ready after reset", {63'h0, in_ready}, 64'd1);

      // Directed corners
      send(32'hFFFF_FFFE, 32'h1234_5007, 1'b0, 2'd0, 32'h0000_0ABC, "R1"); // dir absent
      send(32'h0000_0007, 32'hFFFF_FFFE, 1'b1, 2'd3, 32'h0, "R4");         // page absent beats all
      send(32'h0000_0003, 32'h0000_0005, 1'b1, 2'd3, 32'h0, "R4");         // priv beats write
      send(32'h0000_0007, 32'h0000_0003, 1'b0, 2'd3, 32'h0, "R2");         // page supervisor
      send(32'h0000_0003, 32'hABCD_E003, 1'b1, 2'd2, 32'h0000_0123, "R2"); // level 2 ok
      send(32'h0000_0005, 32'h0000_0007, 1'b1, 2'd0, 32'h0, "R3");         // dir read-only
      send(32'h0000_0007, 32'h0000_0005, 1'b1, 2'd3, 32'h0, "R3");         // page read-only
      send(32'h0000_0027, 32'h5555_5067, 1'b1, 2'd3, 32'hFFFF_FFFF, "R9"); // flags already set
      send(32'h0000_0021, 32'h0000_0001, 1'b0, 2'd1, 32'h0, "R9");         // page only changes
      send(32'h0000_0041, 32'h0000_0019, 1'b0, 2'd0, 32'h0, "R6");         // read: no dirty
      send(32'h0000_0003, 32'h0000_0023, 1'b1, 2'd0, 32'h0, "R6");         // write sets dirty

      // Constrained random
      for (int i = 0; i < 400; i++) begin
         logic [31:0] d, p;
         d = $urandom; p = $urandom;
         d[0] = ($urandom % 8) != 0;
         p[0] = ($urandom % 8) != 0;
         d[2] = ($urandom % 4) != 0;
         p[2] = ($urandom % 4) != 0;
         send(d, p, 1'($urandom), 2'($urandom), $urandom, "");
         if (($urandom % 5) == 0) begin
            @(negedge clk);
            in_valid = 1'b0;
         end
      end
      @(negedge clk);
      in_valid = 1'b0;
      drain = 1'b1;
      repeat (5) @(negedge clk);
      chk("R10", "results outstanding", 64'(exp_q.size()), 64'd0);
      done = 1'b1;
      @(negedge clk);
      summary();
      $finish;
   end
endmodule